// File: doc/BRIEF.md
# Byte-Level I2C Master Command Engine

This block is an I2C master that software drives one bus primitive at a time. A byte-wide register port gives access to six registers: control, clock divider, command and status, data, interrupt-flag clear and interrupt enable. Software writes a command code together with a launch bit. The engine then runs that single primitive on the bus and reports a two-bit result code in the same register. The primitives are start, repeated start, send a byte and sample the acknowledge, receive a byte and answer with ACK or NACK, and stop.

SCL and SDA are open-drain. The engine only asserts an output enable that pulls a line low, and it reads SDA back to sample data, acknowledges and collisions. Each SCL period is built from four equal quarters whose length the divider sets. Every completed command raises a sticky flag, and that flag gated by the enable bit forms the interrupt.

Top module: `i2c_prim_engine`

## Requirements
- R1: After reset, every register reads 0. Both output enables are low, which leaves SCL and SDA released, and irq is low.
- R2: Writing offset 2 with bit 7 set and a known code in bits 3:0 launches that command. Bit 7 reads 1 while the command runs and 0 afterwards. Any write to offset 2 while a command runs has no effect. Offset 2 reads as {busy, status[1:0], 0, code[3:0]}.
- R3: One quarter lasts 16 x (divider + 1) clock cycles. Start, repeated start and stop each take 4 quarters from the launching write. A byte command takes 36 quarters.
- R4: Code 3 sends the data register MSB first. SDA changes only while SCL is low. The ninth SCL-high sample sets status 1 if SDA is low (ACK) and status 2 if SDA is high (NACK).
- R5: Code 6 and code 7 each receive 8 bits MSB first, sampled in the middle of SCL high. Afterwards, offset 3 returns the received byte. In the ninth clock, code 6 drives SDA low and code 7 leaves it released. Status is 0.
- R6: Code 1 pulls SDA low while SCL is high, then pulls SCL low. Code 2 first releases SDA with SCL low, then releases SCL, then does the same start. Code 10 releases SDA while SCL is high and leaves both lines released.
- R7: During one of the 8 data bits of code 3, if the engine releases SDA but samples it low, the command ends at once with status 3 and both lines released.
- R8: Every completion sets a flag that reads at offset 8 bit 0. Writing 1 to bit 0 of offset 8 clears it. irq equals the flag ANDed with bit 0 of offset 10.
- R9: While bit 0 of offset 0 is set, the engine stays idle with both lines released, and launch writes are ignored.
- R10: A launch with an unknown code completes on the next cycle with status 0, sets the flag and does not touch the bus.
- R11: The registers sit at these offsets: control 0, divider 1, command 2, data 3, flag 8, enable 10. Divider, data and enable read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| irq | output | 1 | Completion interrupt |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench uses the default 16-cycle quarter and runs most traffic with divider 0. At that setting a full byte takes 576 cycles, so dozens of randomized sends and receives fit easily in the cycle budget. One pass with divider 2 shows that the period scales with the register value and is not fixed. Small quarters also keep the abort point, the repeated-start edge ordering and the mid-command write within short, exactly countable windows.

// File: rtl/i2c_prim_pkg.sv
package i2c_prim_pkg;

    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] OFF_CTRL  = 4'd0;
    localparam logic [REG_AW-1:0] OFF_DIV   = 4'd1;
    localparam logic [REG_AW-1:0] OFF_CMD   = 4'd2;
    localparam logic [REG_AW-1:0] OFF_DATA  = 4'd3;
    localparam logic [REG_AW-1:0] OFF_FLAG  = 4'd8;
    localparam logic [REG_AW-1:0] OFF_IEN   = 4'd10;

    localparam logic [3:0] LAST_BYTE_SLOT = 4'd8;

    typedef enum logic [3:0] {
        CMD_NONE    = 4'd0,
        CMD_START   = 4'd1,
        CMD_RESTART = 4'd2,
        CMD_SEND    = 4'd3,
        CMD_RD_ACK  = 4'd6,
        CMD_RD_NACK = 4'd7,
        CMD_STOP    = 4'd10
    } cmd_e;

    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_ACK   = 2'd1,
        ST_NACK  = 2'd2,
        ST_ABORT = 2'd3
    } status_e;

    // per-quarter line drive: 1 = pull low; sda_keep holds SDA as it was
    typedef struct packed {
        logic scl_low;
        logic sda_low;
        logic sda_keep;
    } drv_t;

    function automatic logic cmd_known(input logic [3:0] c);
        case (c)
            4'd1, 4'd2, 4'd3, 4'd6, 4'd7, 4'd10: return 1'b1;
            default:                              return 1'b0;
        endcase
    endfunction

    function automatic logic cmd_is_byte(input cmd_e c);
        return (c == CMD_SEND) || (c == CMD_RD_ACK) || (c == CMD_RD_NACK);
    endfunction

    function automatic drv_t quarter_drive(input cmd_e c, input logic [3:0] slot,
                                           input logic [1:0] q, input logic bit_out);
        drv_t d;
        d = '0;
        case (c)
            CMD_START: begin
                d.scl_low = (q == 2'd3);
                d.sda_low = (q >= 2'd2);
            end
            CMD_RESTART: begin
                d.scl_low = (q == 2'd0) || (q == 2'd3);
                d.sda_low = (q >= 2'd2);
            end
            CMD_STOP: begin
                d.scl_low = (q == 2'd0);
                d.sda_low = (q < 2'd2);
            end
            CMD_SEND: begin
                d.scl_low  = (q < 2'd2);
                d.sda_keep = (q == 2'd0);
                d.sda_low  = (slot < LAST_BYTE_SLOT) && !bit_out;
            end
            CMD_RD_ACK, CMD_RD_NACK: begin
                d.scl_low  = (q < 2'd2);
                d.sda_keep = (q == 2'd0);
                d.sda_low  = (slot == LAST_BYTE_SLOT) && (c == CMD_RD_ACK);
            end
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/i2c_quarter_timer.sv
module i2c_quarter_timer #(
    parameter int DIV_W          = 8,
    parameter int QUARTER_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = DIV_W + $clog2(QUARTER_CYCLES) + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] div_ext;
    logic [CNT_W-1:0] lim;

    assign div_ext = CNT_W'(div);
    assign lim     = (div_ext + CNT_W'(1)) * CNT_W'(QUARTER_CYCLES) - CNT_W'(1);
    assign tick    = run && (cnt_q >= lim);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            cnt_q <= '0;
        end else if (cnt_q >= lim) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R3: each quarter boundary restarts the count
    p_tick_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt_q == '0));

endmodule

// File: rtl/i2c_prim_seq.sv
module i2c_prim_seq
    import i2c_prim_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [3:0] code,
    input  logic [7:0] tx_byte,
    input  logic       tick,
    input  logic       sda_in,
    output logic       busy,
    output logic [1:0] status,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       rx_we,
    output logic       scl_oe,
    output logic       sda_oe
);
    logic       busy_q;
    cmd_e       cmd_q;
    logic [3:0] slot_q;
    logic [1:0] q_q;
    logic [7:0] shift_q;
    status_e    status_q;
    logic       done_q;
    logic [7:0] rx_q;
    logic       rx_we_q;
    logic       scl_oe_q;
    logic       sda_oe_q;

    logic       is_byte;
    logic       is_send;
    logic       sample;
    logic       abort_hit;
    logic       slot_end;
    logic       finish;
    logic [3:0] last_slot;
    logic [3:0] slot_nx;
    logic [1:0] q_nx;
    logic [7:0] shift_nx;
    drv_t       drv_nx;
    drv_t       drv_go;

    always_comb begin
        is_byte   = cmd_is_byte(cmd_q);
        is_send   = (cmd_q == CMD_SEND);
        sample    = busy_q && tick && (q_q == 2'd2) && is_byte;
        abort_hit = sample && is_send && (slot_q < LAST_BYTE_SLOT) && shift_q[7] && !sda_in;
        slot_end  = busy_q && tick && (q_q == 2'd3);
        last_slot = is_byte ? LAST_BYTE_SLOT : 4'd0;
        finish    = slot_end && (slot_q == last_slot);
        slot_nx   = slot_end ? slot_q + 4'd1 : slot_q;
        q_nx      = q_q + 2'd1;
        shift_nx  = shift_q;
        if (sample && !is_send && (slot_q < LAST_BYTE_SLOT))
            shift_nx = {shift_q[6:0], sda_in};
        if (slot_end && is_send && (slot_q < LAST_BYTE_SLOT))
            shift_nx = {shift_q[6:0], 1'b0};
        drv_nx = quarter_drive(cmd_q, slot_nx, q_nx, shift_nx[7]);
        drv_go = quarter_drive(cmd_e'(code), 4'd0, 2'd0, tx_byte[7]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            cmd_q    <= CMD_NONE;
            slot_q   <= '0;
            q_q      <= '0;
            shift_q  <= '0;
            status_q <= ST_OK;
            done_q   <= 1'b0;
            rx_q     <= '0;
            rx_we_q  <= 1'b0;
            scl_oe_q <= 1'b0;
            sda_oe_q <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            rx_we_q <= 1'b0;
            if (!busy_q && go) begin
                status_q <= ST_OK;
                if (cmd_known(code)) begin
                    busy_q   <= 1'b1;
                    cmd_q    <= cmd_e'(code);
                    slot_q   <= '0;
                    q_q      <= '0;
                    shift_q  <= tx_byte;
                    scl_oe_q <= drv_go.scl_low;
                    if (!drv_go.sda_keep) sda_oe_q <= drv_go.sda_low;
                end else begin
                    done_q <= 1'b1;
                end
            end else if (busy_q && tick) begin
                if (abort_hit) begin
                    busy_q   <= 1'b0;
                    done_q   <= 1'b1;
                    status_q <= ST_ABORT;
                    scl_oe_q <= 1'b0;
                    sda_oe_q <= 1'b0;
                end else if (finish) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    if (is_byte && !is_send) begin
                        rx_q    <= shift_q;
                        rx_we_q <= 1'b1;
                    end
                    if (cmd_q == CMD_STOP) begin
                        scl_oe_q <= 1'b0;
                        sda_oe_q <= 1'b0;
                    end else begin
                        scl_oe_q <= 1'b1;
                    end
                end else begin
                    slot_q   <= slot_nx;
                    q_q      <= q_nx;
                    shift_q  <= shift_nx;
                    scl_oe_q <= drv_nx.scl_low;
                    if (!drv_nx.sda_keep) sda_oe_q <= drv_nx.sda_low;
                    if (sample && is_send && (slot_q == LAST_BYTE_SLOT))
                        status_q <= sda_in ? ST_NACK : ST_ACK;
                end
            end
        end
    end

    assign busy    = busy_q;
    assign status  = status_q;
    assign done    = done_q;
    assign rx_byte = rx_q;
    assign rx_we   = rx_we_q;
    assign scl_oe  = scl_oe_q;
    assign sda_oe  = sda_oe_q;

    // R4: inside a byte command SDA only moves after a cycle of SCL held low
    p_sda_scl_low_r4: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q) && is_byte && (sda_oe_q != $past(sda_oe_q)))
        |-> $past(scl_oe_q));

    // R3: quarters advance only on a timer tick
    p_quarter_tick_r3: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q) && (q_q != $past(q_q))) |-> $past(tick));

    // R7: an aborted command leaves both lines released
    p_abort_release_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && (status_q == ST_ABORT)) |-> (!scl_oe_q && !sda_oe_q));

endmodule

// File: rtl/i2c_prim_engine.sv
module i2c_prim_engine
    import i2c_prim_pkg::*;
#(
    parameter int DIV_W          = 8,
    parameter int QUARTER_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe
);
    logic             lrst_q;
    logic [DIV_W-1:0] div_q;
    logic [3:0]       code_q;
    logic [7:0]       data_q;
    logic             flag_q;
    logic             ien_q;

    logic       eng_rst;
    logic       go;
    logic       busy;
    logic [1:0] status;
    logic       done;
    logic [7:0] rx_byte;
    logic       rx_we;
    logic       tick;

    assign eng_rst = rst || lrst_q;
    assign go = reg_wr && (reg_addr == OFF_CMD) && reg_wdata[7] && !busy && !lrst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lrst_q <= 1'b0;
            div_q  <= '0;
            code_q <= '0;
            data_q <= '0;
            ien_q  <= 1'b0;
        end else begin
            if (reg_wr && (reg_addr == OFF_CTRL)) lrst_q <= reg_wdata[0];
            if (reg_wr && (reg_addr == OFF_DIV))  div_q  <= reg_wdata[DIV_W-1:0];
            if (reg_wr && (reg_addr == OFF_CMD) && !busy) code_q <= reg_wdata[3:0];
            if (reg_wr && (reg_addr == OFF_IEN))  ien_q  <= reg_wdata[0];
            if (rx_we)
                data_q <= rx_byte;
            else if (reg_wr && (reg_addr == OFF_DATA))
                data_q <= reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (eng_rst)
            flag_q <= 1'b0;
        else if (done)
            flag_q <= 1'b1;
        else if (reg_wr && (reg_addr == OFF_FLAG) && reg_wdata[0])
            flag_q <= 1'b0;
    end

    i2c_quarter_timer #(
        .DIV_W         (DIV_W),
        .QUARTER_CYCLES(QUARTER_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst    (eng_rst),
        .run    (busy),
        .restart(go),
        .div    (div_q),
        .tick   (tick)
    );

    i2c_prim_seq u_seq (
        .clk    (clk),
        .rst    (eng_rst),
        .go     (go),
        .code   (reg_wdata[3:0]),
        .tx_byte(data_q),
        .tick   (tick),
        .sda_in (sda_in),
        .busy   (busy),
        .status (status),
        .done   (done),
        .rx_byte(rx_byte),
        .rx_we  (rx_we),
        .scl_oe (scl_oe),
        .sda_oe (sda_oe)
    );

    always_comb begin
        case (reg_addr)
            OFF_CTRL: reg_rdata = {7'd0, lrst_q};
            OFF_DIV:  reg_rdata = 8'(div_q);
            OFF_CMD:  reg_rdata = {busy, status, 1'b0, code_q};
            OFF_DATA: reg_rdata = data_q;
            OFF_FLAG: reg_rdata = {7'd0, flag_q};
            OFF_IEN:  reg_rdata = {7'd0, ien_q};
            default:  reg_rdata = 8'd0;
        endcase
    end

    assign irq = flag_q && ien_q;

    // R2: the stored command code cannot change while a command runs
    p_cmd_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(code_q));

    // R8: the flag only rises after a completion pulse
    p_flag_done_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(done));

    // R9: local reset holds the engine idle with lines released
    p_lrst_idle_r9: assert property (@(posedge clk) disable iff (rst)
        $past(lrst_q) |-> (!busy && !scl_oe && !sda_oe));

endmodule

// File: tb/test_i2c_prim_engine.sv
`timescale 1ns/100ps
module test_i2c_prim_engine;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;
    logic       scl_oe;
    logic       sda_oe;
    logic       pull = 1'b0;
    logic       sda_line;

    int tests = 0;
    int fails = 0;
    int q_len = 16;

    int         starts = 0;
    int         stops = 0;
    int         rises = 0;
    logic [8:0] mon_bits = '0;
    logic       prev_scl = 1'b1;
    logic       prev_sda = 1'b1;

    always #2.5 clk = ~clk;

    assign sda_line = !(sda_oe || pull);

    i2c_prim_engine i_i2c_prim_engine (
        .clk      (clk),
        .rst      (rst),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq      (irq),
        .sda_in   (sda_line),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe)
    );

    // bus monitor: bits on SCL rise, start/stop conditions
    always @(posedge clk) begin
        logic scl_l;
        scl_l = !scl_oe;
        if (!prev_scl && scl_l) begin
            mon_bits = {mon_bits[7:0], sda_line};
            rises++;
        end
        if (prev_scl && scl_l && prev_sda && !sda_line) starts++;
        if (prev_scl && scl_l && !prev_sda && sda_line) stops++;
        prev_scl = scl_l;
        prev_sda = sda_line;
    end

    function automatic int exp_cycles(input int quarters, input int div);
        return quarters * 16 * (div + 1);
    endfunction

    function automatic logic [7:0] exp_cmd_reg(input logic [1:0] st, input logic [3:0] code);
        return {1'b0, st, 1'b0, code};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    // launch, play target pulls per slot, count cycles until idle
    task automatic run_cmd(input logic [7:0] cmdbyte, input logic [8:0] pull9, output int dur);
        int n;
        n = 0;
        wr(4'd2, cmdbyte);
        reg_addr = 4'd2;
        forever begin
            int slot;
            slot = n / (4 * q_len);
            pull = (slot < 9) ? pull9[8 - slot] : 1'b0;
            #0.5;
            if (!reg_rdata[7]) break;
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n > 20000) break;
        end
        pull = 1'b0;
        dur  = n;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int d, s0, p0, r0;
        logic [31:0] seed;
        seed = $urandom(32'd2024);

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(4'd0, v);  check("R1 ctrl", v, 0);
        rd(4'd1, v);  check("R1 div", v, 0);
        rd(4'd2, v);  check("R1 cmd", v, 0);
        rd(4'd3, v);  check("R1 data", v, 0);
        rd(4'd8, v);  check("R1 flag", v, 0);
        rd(4'd10, v); check("R1 ien", v, 0);
        check("R1 lines", {scl_oe, sda_oe, irq}, 0);

        // R11 register map
        wr(4'd1, 8'h5A); rd(4'd1, v); check("R11 div", v, 8'h5A);
        wr(4'd3, 8'hC3); rd(4'd3, v); check("R11 data", v, 8'hC3);
        wr(4'd10, 8'h01); rd(4'd10, v); check("R11 ien", v, 1);
        wr(4'd1, 8'h00);

        // R6 start, R3 timing, R8 interrupt
        s0 = starts;
        run_cmd(8'h81, 9'd0, d);
        check("R3 start duration", d, exp_cycles(4, 0));
        check("R6 start condition", starts - s0, 1);
        check("R6 start leaves lines low", {scl_oe, sda_oe}, 2'b11);
        rd(4'd2, v); check("R2 cmd reg after start", v, exp_cmd_reg(2'd0, 4'd1));
        check("R8 irq set", irq, 1);
        wr(4'd8, 8'h01);
        @(negedge clk);
        check("R8 irq cleared", irq, 0);
        rd(4'd8, v); check("R8 flag cleared", v, 0);

        // R4 random sends plus directed extremes
        for (int i = 0; i < 8; i++) begin
            logic [7:0] tx;
            logic ack;
            tx  = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'($urandom);
            ack = (i == 1) ? 1'b1 : 1'($urandom);
            s0 = starts; p0 = stops;
            wr(4'd3, tx);
            run_cmd(8'h83, {8'd0, ack}, d);
            check("R4 bits on bus", mon_bits, {tx, !ack});
            rd(4'd2, v); check("R4 ack status", v, exp_cmd_reg(ack ? 2'd1 : 2'd2, 4'd3));
            check("R3 byte duration", d, exp_cycles(36, 0));
            check("R4 no start/stop inside byte", (starts - s0) + (stops - p0), 0);
            rd(4'd8, v); check("R8 flag per command", v, 1);
            wr(4'd8, 8'h01);
        end

        // R5 random receives
        for (int i = 0; i < 8; i++) begin
            logic [7:0] rx;
            logic [3:0] code;
            rx   = 8'($urandom);
            code = (i[0]) ? 4'd7 : 4'd6;
            run_cmd({4'h8, code}, {~rx, 1'b0}, d);
            rd(4'd3, v); check("R5 received byte", v, rx);
            check("R5 ninth bit drive", mon_bits[0], (code == 4'd7) ? 1 : 0);
            rd(4'd2, v); check("R5 status normal", v, exp_cmd_reg(2'd0, code));
        end

        // R6 repeated start
        s0 = starts; r0 = rises;
        run_cmd(8'h82, 9'd0, d);
        check("R6 restart start condition", starts - s0, 1);
        check("R6 restart one SCL rise", rises - r0, 1);
        check("R3 restart duration", d, exp_cycles(4, 0));

        // R6 stop
        p0 = stops;
        run_cmd(8'h8A, 9'd0, d);
        check("R6 stop condition", stops - p0, 1);
        check("R6 stop releases lines", {scl_oe, sda_oe}, 0);

        // R7 abort on first data bit
        run_cmd(8'h81, 9'd0, d);
        wr(4'd3, 8'hB5);
        run_cmd(8'h83, 9'b1_0000_0000, d);
        check("R7 abort time", d, exp_cycles(3, 0));
        rd(4'd2, v); check("R7 abort status", v, exp_cmd_reg(2'd3, 4'd3));
        check("R7 lines released", {scl_oe, sda_oe}, 0);

        // R2 write while busy ignored
        run_cmd(8'h81, 9'd0, d);
        wr(4'd3, 8'h3C);
        wr(4'd2, 8'h83);
        repeat (100) @(negedge clk);
        p0 = stops;
        wr(4'd2, 8'h8A);
        reg_addr = 4'd2;
        for (int k = 0; k < 2000; k++) begin
            #0.5;
            if (!reg_rdata[7]) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        rd(4'd2, v); check("R2 busy write ignored", v, exp_cmd_reg(2'd2, 4'd3));
        check("R2 no stop issued", stops - p0, 0);
        check("R2 byte still sent", mon_bits, {8'h3C, 1'b1});

        // R10 unknown code
        wr(4'd8, 8'h01);
        run_cmd(8'h85, 9'd0, d);
        check("R10 immediate", d, 0);
        rd(4'd2, v); check("R10 status", v, exp_cmd_reg(2'd0, 4'd5));
        rd(4'd8, v); check("R10 flag", v, 1);

        // R8 enable gating
        wr(4'd10, 8'h00);
        run_cmd(8'h8A, 9'd0, d);
        rd(4'd8, v); check("R8 flag while disabled", v, 1);
        check("R8 irq gated", irq, 0);

        // R9 local reset
        run_cmd(8'h81, 9'd0, d);
        wr(4'd0, 8'h01);
        @(negedge clk);
        check("R9 lines released", {scl_oe, sda_oe}, 0);
        wr(4'd2, 8'h81);
        @(negedge clk);
        rd(4'd2, v); check("R9 launch ignored", v[7], 0);
        check("R9 bus idle", {scl_oe, sda_oe}, 0);
        rd(4'd0, v); check("R9 ctrl readback", v, 1);
        wr(4'd0, 8'h00);

        // R3 divider scaling
        wr(4'd1, 8'h02);
        q_len = 48;
        run_cmd(8'h81, 9'd0, d);
        check("R3 start duration div2", d, exp_cycles(4, 2));
        wr(4'd3, 8'h96);
        run_cmd(8'h83, 9'd1, d);
        check("R3 byte duration div2", d, exp_cycles(36, 2));
        check("R4 bits div2", mon_bits, {8'h96, 1'b0});
        run_cmd(8'h8A, 9'd0, d);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule